// File: doc/BRIEF.md
# Halfword-to-Word Host Access Combiner

This block sits between a 16-bit parallel host port and a 32-bit internal register bus on which every register can only be read or written as one whole word. The host splits each 32-bit access into two halfword accesses. For a write, the halfword at the lower address (address bit 1 clear) is parked in a staging register, and the internal register does not change. When the halfword at the upper address (address bit 1 set) of the same word arrives, both halves go out together as one 32-bit write. The first halfword is placed in bits 31:16 and the second in bits 15:0. So writing 0x1234 to the lower half and then 0x5678 to the upper half leaves the register holding 0x12345678.

Reads are split the same way. A read of the lower half fetches the whole word, returns bits 31:16 and keeps bits 15:0 in a read latch. A following read of the upper half of that word is answered from the latch without touching the bus. While an internal transfer is outstanding, the ready output is low. An upper-half write that has no matching staged lower half is dropped, and a sticky error flag is set.

The controller is a three-state machine:
- ST_IDLE: waits for host strobes.
- ST_WCOMMIT: holds a 32-bit write request until it is acknowledged.
- ST_RFETCH: holds a 32-bit read request until it is acknowledged.

The transitions are:
- ST_IDLE to ST_WCOMMIT on an upper-half write that matches the staged word.
- ST_IDLE to ST_RFETCH on a read that the latch cannot answer.
- Each busy state returns to ST_IDLE on the acknowledge.

An access is taken on the first clock at which chip select and the read or write enable are both low, and only while ready is high. A write takes priority over a read that starts on the same clock.

Top module: `host_wr_combiner`

## Requirements
- R1: After reset, host_rdy is 1, ib_req is 0, host_err is 0 and host_rdata is 0.
- R2: A write to a lower half (address bit 1 = 0) raises no internal request, and the internal register keeps its old value.
- R3: A write to the upper half (address bit 1 = 1) of the staged word issues exactly one 32-bit write to word address host_addr[10:2]. The staged halfword is in bits 31:16 and the new halfword in bits 15:0.
- R4: From the clock that takes a committing write, or a read needing a fetch, host_rdy is 0 until the clock on which ib_ack is seen. During that time ib_req stays high and the address, direction and write data stay stable. With an acknowledge L cycles after the request, ready is low for L cycles.
- R5: An upper-half write with no staged lower half, or with a staged lower half of a different word, issues no internal write and sets host_err. host_err stays 1 until reset.
- R6: A read of a lower half fetches the word and returns its bits 31:16 on host_rdata.
- R7: A read of the upper half of the word last fetched by a lower-half read returns that word's bits 15:0 without any internal read.
- R8: A read of an upper half that the latch does not hold fetches the word and returns its bits 15:0.
- R9: A committed write to the word held in the read latch invalidates the latch, so a later upper-half read fetches the new value.
- R10: A second lower-half write replaces the staged halfword; only the latest one is committed.
- R11: A commit consumes the staging register, so a repeated upper-half write issues no internal write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read enable, active low |
| host_wr_n | input | 1 | Host write enable, active low |
| host_addr | input | 10 | Host halfword address, byte address bits 10:1 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid once host_rdy is high after a read |
| host_rdy | output | 1 | High when a new host access may start |
| host_err | output | 1 | Sticky flag for a dropped upper-half write |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_we | output | 1 | Internal bus direction, 1 for write |
| ib_addr | output | 9 | Internal 32-bit word address |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data, valid with ib_ack |
| ib_ack | input | 1 | Internal bus acknowledge |

## Verification
The main path is tried with several write patterns:
- A lower-then-upper pair, which separates correct packing from swapped halves.
- An upper half with nothing staged, and an upper half of a different word, which separate a checked commit from a blind one.
- Two lower halves before one upper half, which shows whether staging keeps the latest value.
- A repeated upper half, which shows whether the commit consumes the staging register.

Reads are tried in three patterns:
- Lower then upper, which must use the latch with no internal read.
- Upper alone, which must fetch.
- Lower, then a write to that word, then upper, which exposes a stale latch.

An internal bus model with an adjustable acknowledge delay lets the bench count how many cycles ready stays low.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WCOMMIT  = 2'd1,
        ST_RFETCH   = 2'd2
    } hwc_state_e;

endpackage

// File: rtl/hwc_strobe.sv
module hwc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_go,
    output logic rd_go
);
    logic wr_act, rd_act;
    logic wr_prev_q, rd_prev_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev_q <= 1'b0;
            rd_prev_q <= 1'b0;
        end else begin
            wr_prev_q <= wr_act;
            rd_prev_q <= rd_act;
        end
    end

    // one pulse at the start of each strobe
    assign wr_go = wr_act && !wr_prev_q;
    assign rd_go = rd_act && !rd_prev_q;
endmodule

// File: rtl/hwc_stage.sv
module hwc_stage #(
    parameter int WAW = 9,
    parameter int HDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           clear,
    input  logic [WAW-1:0] load_addr,
    input  logic [HDW-1:0] load_data,
    output logic           vld,
    output logic [WAW-1:0] addr,
    output logic [HDW-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            addr <= '0;
            data <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            addr <= load_addr;
            data <= load_data;
        end else if (clear) begin
            vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/hwc_rdlatch.sv
module hwc_rdlatch #(
    parameter int WAW = 9,
    parameter int HDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           inval,
    input  logic [WAW-1:0] load_addr,
    input  logic [HDW-1:0] load_data,
    output logic           vld,
    output logic [WAW-1:0] addr,
    output logic [HDW-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            addr <= '0;
            data <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            addr <= load_addr;
            data <= load_data;
        end else if (inval) begin
            vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/host_wr_combiner.sv
module host_wr_combiner
    import hwc_pkg::*;
#(
    parameter int HADDR_W = 11,
    parameter int HDATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_cs_n,
    input  logic                   host_rd_n,
    input  logic                   host_wr_n,
    input  logic [HADDR_W-1:1]     host_addr,
    input  logic [HDATA_W-1:0]     host_wdata,
    output logic [HDATA_W-1:0]     host_rdata,
    output logic                   host_rdy,
    output logic                   host_err,
    output logic                   ib_req,
    output logic                   ib_we,
    output logic [HADDR_W-3:0]     ib_addr,
    output logic [2*HDATA_W-1:0]   ib_wdata,
    input  logic [2*HDATA_W-1:0]   ib_rdata,
    input  logic                   ib_ack
);
    localparam int WAW = HADDR_W - 2;
    localparam int IDW = 2 * HDATA_W;

    hwc_state_e state_q, state_d;

    logic           wr_go, rd_go, wr_take, rd_take;
    logic           upper;
    logic [WAW-1:0] word;
    logic           stg_vld, stg_hit, commit;
    logic [WAW-1:0] stg_addr;
    logic [HDATA_W-1:0] stg_data;
    logic           rl_vld, rl_hit, rl_load, rl_inval;
    logic [WAW-1:0] rl_addr;
    logic [HDATA_W-1:0] rl_data;
    logic           rd_upper_q;
    logic [WAW-1:0] addr_q;
    logic [IDW-1:0] wdata_q;
    logic [HDATA_W-1:0] rdata_q;
    logic           err_q;

    hwc_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (host_cs_n),
        .rd_n  (host_rd_n),
        .wr_n  (host_wr_n),
        .wr_go (wr_go),
        .rd_go (rd_go)
    );

    assign upper   = host_addr[1];
    assign word    = host_addr[HADDR_W-1:2];
    assign wr_take = wr_go && (state_q == ST_IDLE);
    assign rd_take = rd_go && !wr_go && (state_q == ST_IDLE);
    assign stg_hit = stg_vld && (stg_addr == word);
    assign rl_hit  = rl_vld && (rl_addr == word);
    assign commit  = wr_take && upper && stg_hit;

    hwc_stage #(.WAW(WAW), .HDW(HDATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_take && !upper),
        .clear     (commit),
        .load_addr (word),
        .load_data (host_wdata),
        .vld       (stg_vld),
        .addr      (stg_addr),
        .data      (stg_data)
    );

    assign rl_load  = (state_q == ST_RFETCH) && ib_ack && !rd_upper_q;
    assign rl_inval = commit && rl_hit;

    hwc_rdlatch #(.WAW(WAW), .HDW(HDATA_W)) u_rdlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rl_load),
        .inval     (rl_inval),
        .load_addr (addr_q),
        .load_data (ib_rdata[HDATA_W-1:0]),
        .vld       (rl_vld),
        .addr      (rl_addr),
        .data      (rl_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (commit)
                    state_d = ST_WCOMMIT;
                else if (rd_take && !(upper && rl_hit))
                    state_d = ST_RFETCH;
            end
            ST_WCOMMIT: if (ib_ack) state_d = ST_IDLE;
            ST_RFETCH:  if (ib_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_upper_q <= 1'b0;
            rdata_q    <= '0;
            err_q      <= 1'b0;
        end else begin
            if (commit) begin
                addr_q  <= word;
                wdata_q <= {stg_data, host_wdata};
            end
            if (wr_take && upper && !stg_hit)
                err_q <= 1'b1;
            if (rd_take) begin
                addr_q     <= word;
                rd_upper_q <= upper;
                if (upper && rl_hit)
                    rdata_q <= rl_data;
            end
            if (state_q == ST_RFETCH && ib_ack)
                rdata_q <= rd_upper_q ? ib_rdata[HDATA_W-1:0]
                                      : ib_rdata[IDW-1:HDATA_W];
        end
    end

    // outputs
    always_comb begin
        host_rdy = (state_q == ST_IDLE);
        ib_req   = (state_q != ST_IDLE);
        ib_we    = (state_q == ST_WCOMMIT);
    end

    assign ib_addr    = addr_q;
    assign ib_wdata   = wdata_q;
    assign host_rdata = rdata_q;
    assign host_err   = err_q;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
    parameter int HADDR_W = 11,
    parameter int HDATA_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_cs_n,
    input logic                 host_wr_n,
    input logic [HADDR_W-1:1]   host_addr,
    input logic                 host_rdy,
    input logic                 host_err,
    input logic                 ib_req,
    input logic                 ib_we,
    input logic [HADDR_W-3:0]   ib_addr,
    input logic [2*HDATA_W-1:0] ib_wdata,
    input logic                 ib_ack
);
    logic wr_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen_q <= 1'b0;
        else        wr_seen_q <= !host_cs_n && !host_wr_n;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> host_rdy && !ib_req);

    a_r2_lower_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && !host_wr_n && !wr_seen_q && host_rdy && !host_addr[1])
        |=> !ib_req);

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> ib_req && $stable(ib_addr) && $stable(ib_we)
                                && $stable(ib_wdata));

    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> !host_rdy);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> host_err);
endmodule

bind host_wr_combiner hwc_checker #(.HADDR_W(HADDR_W), .HDATA_W(HDATA_W)) u_chk (.*);

// File: tb/sim_host_wr_combiner.sv
module sim_host_wr_combiner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_cs_n, host_rd_n, host_wr_n;
    logic [10:1] host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        host_rdy, host_err;
    logic        ib_req, ib_we;
    logic [8:0]  ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata;
    logic        ib_ack;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int cnt = 0;
    int n_iwr = 0;
    int n_ird = 0;
    logic [31:0] mem [512];

    always #10 clk = ~clk;

    host_wr_combiner u0 (.*);

    function automatic logic [31:0] pre(input int i);
        return {16'(i) ^ 16'hC3C3, ~16'(i)};
    endfunction

    // internal bus model, acting on falling edges
    initial begin
        ib_ack = 1'b0;
        ib_rdata = '0;
        for (int i = 0; i < 512; i++) mem[i] = pre(i);
        forever begin
            @(negedge clk);
            if (ib_req && !ib_ack) begin
                cnt++;
                if (cnt >= lat) begin
                    ib_ack = 1'b1;
                    if (ib_we) begin
                        mem[ib_addr] = ib_wdata;
                        n_iwr++;
                    end else begin
                        ib_rdata = mem[ib_addr];
                        n_ird++;
                    end
                end
            end else begin
                ib_ack = 1'b0;
                cnt = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw_write(input logic [11:0] a, input logic [15:0] d, output int low);
        @(negedge clk);
        host_addr = a[10:1]; host_wdata = d;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        low = 0;
        while (!host_rdy) begin
            low++;
            @(negedge clk);
        end
    endtask

    task automatic hw_read(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a[10:1];
        host_cs_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        while (!host_rdy) @(negedge clk);
        d = host_rdata;
    endtask

    // {is_read, byte address, write data, expected read data}
    localparam logic [44:0] VEC [10] = '{
        {1'b0, 12'h400, 16'h1234, 16'h0000},
        {1'b0, 12'h402, 16'h5678, 16'h0000},
        {1'b1, 12'h400, 16'h0000, 16'h1234},
        {1'b1, 12'h402, 16'h0000, 16'h5678},
        {1'b0, 12'h010, 16'hAAAA, 16'h0000},
        {1'b0, 12'h012, 16'h5555, 16'h0000},
        {1'b1, 12'h012, 16'h0000, 16'h5555},
        {1'b1, 12'h010, 16'h0000, 16'hAAAA},
        {1'b1, 12'h7FC, 16'h0000, 16'hC23C},
        {1'b1, 12'h7FE, 16'h0000, 16'hFE00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int low, w0, r0;
        logic [15:0] rd;
        rst_n = 1'b0;
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdy", {31'd0, host_rdy}, 32'd1);
        chk("R1 req", {31'd0, ib_req}, 32'd0);
        chk("R1 err", {31'd0, host_err}, 32'd0);
        chk("R1 rdata", {16'd0, host_rdata}, 32'd0);

        // table walk: R3, R6, R7, R8 patterns
        for (int k = 0; k < 10; k++) begin
            if (VEC[k][44]) begin
                hw_read(VEC[k][43:32], rd);
                chk($sformatf("R6/R7/R8 vector %0d", k), {16'd0, rd}, {16'd0, VEC[k][15:0]});
            end else begin
                hw_write(VEC[k][43:32], VEC[k][31:16], low);
            end
        end
        chk("R3 packing word 0x100", mem[9'h100], 32'h12345678);
        chk("R3 packing word 0x004", mem[9'h004], 32'hAAAA5555);
        chk("R3 write count", n_iwr, 2);

        // R7 latch hit issues no internal read
        hw_read(12'h400, rd);
        r0 = n_ird;
        hw_read(12'h402, rd);
        chk("R7 upper from latch", {16'd0, rd}, 32'h5678);
        chk("R7 no internal read", n_ird, r0);

        // R2 lower write alone
        w0 = n_iwr;
        hw_write(12'h020, 16'hBEEF, low);
        chk("R2 ready stays high", low, 0);
        chk("R2 no internal write", n_iwr, w0);
        chk("R2 register unchanged", mem[8], pre(8));

        // R4 ready low for the acknowledge latency
        lat = 3;
        hw_write(12'h022, 16'hF00D, low);
        chk("R4 ready low cycles", low, 3);
        chk("R4/R3 committed word", mem[8], 32'hBEEFF00D);
        lat = 1;

        // R10 second lower write replaces staged half
        hw_write(12'h050, 16'h1111, low);
        hw_write(12'h050, 16'h2222, low);
        hw_write(12'h052, 16'h3333, low);
        chk("R10 latest staged half", mem[9'h014], 32'h22223333);
        chk("R5 no error yet", {31'd0, host_err}, 32'd0);

        // R11 repeated upper write dropped
        w0 = n_iwr;
        hw_write(12'h052, 16'h4444, low);
        chk("R11 no second commit", n_iwr, w0);
        chk("R11 word unchanged", mem[9'h014], 32'h22223333);
        chk("R5 error after unstaged upper", {31'd0, host_err}, 32'd1);

        // R5 mismatched word dropped, error sticky
        hw_write(12'h050, 16'h7777, low);
        w0 = n_iwr;
        hw_write(12'h046, 16'h6666, low);
        chk("R5 mismatched word not written", n_iwr, w0);
        chk("R5 word 0x011 unchanged", mem[9'h011], pre(9'h011));
        repeat (3) @(negedge clk);
        chk("R5 error sticky", {31'd0, host_err}, 32'd1);

        // R9 commit invalidates the read latch
        hw_read(12'h060, rd);
        chk("R6 lower read", {16'd0, rd}, {16'd0, pre(9'h018) >> 16});
        hw_write(12'h060, 16'h9999, low);
        hw_write(12'h062, 16'h8888, low);
        r0 = n_ird;
        hw_read(12'h062, rd);
        chk("R9 fresh upper half", {16'd0, rd}, 32'h8888);
        chk("R9 refetched", n_ird, r0 + 1);

        // R1 reset clears the error
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 error cleared by reset", {31'd0, host_err}, 32'd0);
        chk("R1 rdata cleared by reset", {16'd0, host_rdata}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule